// File: doc/BRIEF.md
# Toggle-Strobe Parallel Link Receiver

This block sits at the receiving end of a point-to-point parallel cable. The two ends use a toggling strobe handshake. While idle, the block watches its incoming strobe line. When that line rises, the sender is asking for a transfer. The receiver then latches its configured link width, either a 4-bit nibble or an 8-bit byte per unit. It advertises that width on its data drive pins and sets its control drive pins for reading. Each unit the sender presents is taken when the incoming strobe changes level, and the receiver acknowledges it by inverting its own strobe drive.

A packet opens with a four-byte header. The header holds a 16-bit length, low byte first, followed by the bitwise complement of that length, also low byte first. The payload is streamed out only when the two copies agree. It comes out one byte per valid pulse, and the final byte is marked. When the packet is complete, the receiver waits for the sender's strobe to fall, then releases its own strobe and returns to idle. A header that fails the check, or a handshake that stalls, raises a one-cycle error pulse and returns the block to idle.

Top module: `lnk_rx`

## Requirements
- R1: After reset, `data_out`, `ctrl_out`, `pay_valid`, `pay_last` and `rx_err` are all zero.
- R2: While idle, a rising level on `stat_in[3]` starts a transfer. The receiver then drives `data_out[3]` high, drives `data_out[0]` with the latched width (1 = byte, 0 = nibble), and drives `ctrl_out` to 4'b0100. All other data bits stay 0.
- R3: While idle with `stat_in[3]` steady, changes on the other inputs leave the outputs unchanged. `cfg_byte_mode` is read only at the start of a transfer, so changing it mid-transfer has no effect.
- R4: A unit's low nibble is {~stat_in[4], stat_in[2], stat_in[1], stat_in[0]}, written as bits 3 down to 0. In byte mode, `ctrl_in[3:0]` supplies bits 7 to 4, and each unit is one byte.
- R5: In nibble mode, two units make one byte, and the first unit supplies the low nibble.
- R6: A new unit is taken whenever the synchronized `stat_in[3]` differs from its last captured level. Each unit inverts `data_out[3]`, so during a transfer `data_out[3]` follows the sender's strobe level.
- R7: Header bytes 2 and 3 must equal the complement of bytes 0 and 1. On a mismatch, `rx_err` pulses, `data_out` and `ctrl_out` return to zero, and no payload is emitted.
- R8: A valid header of length N yields exactly N `pay_valid` pulses, carrying the payload bytes in order. `pay_last` is set only with the N-th byte.
- R9: A length of zero emits no payload and goes straight to the closing wait.
- R10: After the final unit, `data_out[3]` holds until `stat_in[3]` is low. The receiver then drives `data_out` and `ctrl_out` to zero and becomes idle.
- R11: If `TMO_CYC` cycles pass with no new unit while a transfer is active, `rx_err` pulses and the block returns to idle with all drives at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_byte_mode | input | 1 | Requested width: 1 = byte, 0 = nibble |
| stat_in | input | 5 | Status lines; bit 3 is the incoming strobe, bit 4 arrives inverted |
| ctrl_in | input | 4 | Control lines read as the upper nibble in byte mode |
| data_out | output | 8 | Data pin drive; bit 3 is the ack strobe, bit 0 is the advertised width |
| ctrl_out | output | 4 | Control pin drive |
| pay_valid | output | 1 | Payload byte valid, one cycle |
| pay_data | output | 8 | Payload byte |
| pay_last | output | 1 | Marks the final payload byte |
| rx_err | output | 1 | One-cycle pulse on header mismatch or timeout |

## Verification
The bench builds the block with `TMO_CYC` = 40 and the default two-stage synchronizer. With that timeout, a stalled handshake is reached in a few dozen cycles, while normal unit spacing stays well inside the limit. The bench runs byte and nibble packets, a zero-length packet, a corrupted header, and a stall. It then runs a byte-mode packet straight after the stall, which shows that a half-filled nibble left by the stall is discarded.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAY, ST_FIN} lnk_st_e;
   localparam int          LEN_W       = 16;
   localparam int          HDR_BYTES   = 4;
   localparam logic [3:0]  CTRL_ACTIVE = 4'b0100;
endpackage

// File: rtl/lnk_sync.sv
module lnk_sync #(
   parameter int W   = 1,
   parameter int STG = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STG < 2) begin : g_bad_stg
      $error("lnk_sync: STG must be at least 2");
   end

   logic [STG-1:0][W-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[STG-2:0], d};
   end

   assign q = pipe_q[STG-1];
endmodule

// File: rtl/lnk_asm.sv
module lnk_asm (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       byte_mode,
   input  logic       unit_v,
   input  logic [3:0] nib,
   input  logic [3:0] hi,
   output logic       byte_v,
   output logic [7:0] byte_d
);
   logic       half_q;
   logic [3:0] lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q <= 1'b0;
         lo_q   <= '0;
      end else if (clr) begin
         half_q <= 1'b0;
      end else if (unit_v && !byte_mode) begin
         half_q <= ~half_q;
         if (!half_q) lo_q <= nib;
      end
   end

   assign byte_v = unit_v && (byte_mode || half_q);
   assign byte_d = byte_mode ? {hi, nib} : {nib, lo_q};

   AST_BYTE_NO_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_mode && !clr) |-> !half_q); // R4
endmodule

// File: rtl/lnk_rx.sv
module lnk_rx
   import lnk_pkg::*;
#(
   parameter int SYNC_STG = 2,
   parameter int TMO_CYC  = 100000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_byte_mode,
   input  logic [4:0] stat_in,
   input  logic [3:0] ctrl_in,
   output logic [7:0] data_out,
   output logic [3:0] ctrl_out,
   output logic       pay_valid,
   output logic [7:0] pay_data,
   output logic       pay_last,
   output logic       rx_err
);
   localparam int TMO_W = $clog2(TMO_CYC);

   if (TMO_CYC < 16) begin : g_bad_tmo
      $error("lnk_rx: TMO_CYC must be at least 16");
   end

   logic [8:0] sin_q;
   lnk_sync #(.W(9), .STG(SYNC_STG)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({ctrl_in, stat_in}), .q(sin_q));

   logic       s_strb;
   logic [3:0] s_nib, s_hi;
   assign s_strb = sin_q[3];
   assign s_nib  = {~sin_q[4], sin_q[2:0]};
   assign s_hi   = sin_q[8:5];

   lnk_st_e                st_q;
   logic                   strb_d, last_q, ack_q, mode_q;
   logic [1:0]             hcnt_q;
   logic [3:0][7:0]        hdr_q;
   logic [LEN_W-1:0]       rem_q;
   logic [TMO_W-1:0]       tmo_q;

   logic                   active, wake, unit_new, tmo_hit, byte_v, hdr_ok;
   logic [7:0]             byte_d;
   logic [LEN_W-1:0]       hdr_len, hdr_inv;

   assign active   = (st_q != ST_IDLE);
   assign wake     = (st_q == ST_IDLE) && s_strb && !strb_d;
   assign unit_new = ((st_q == ST_HDR) || (st_q == ST_PAY)) && (s_strb != last_q);
   assign tmo_hit  = active && !unit_new && (tmo_q == TMO_W'(TMO_CYC - 1));
   assign hdr_len  = {hdr_q[1], hdr_q[0]};
   assign hdr_inv  = ~{byte_d, hdr_q[2]};
   assign hdr_ok   = (hdr_len == hdr_inv);

   lnk_asm u_asm (
      .clk(clk), .rst_n(rst_n), .clr(wake), .byte_mode(mode_q),
      .unit_v(unit_new), .nib(s_nib), .hi(s_hi),
      .byte_v(byte_v), .byte_d(byte_d));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         strb_d    <= 1'b0;
         last_q    <= 1'b0;
         ack_q     <= 1'b0;
         mode_q    <= 1'b0;
         hcnt_q    <= '0;
         hdr_q     <= '0;
         rem_q     <= '0;
         tmo_q     <= '0;
         pay_valid <= 1'b0;
         pay_data  <= '0;
         pay_last  <= 1'b0;
         rx_err    <= 1'b0;
      end else begin
         strb_d    <= s_strb;
         pay_valid <= 1'b0;
         pay_last  <= 1'b0;
         rx_err    <= 1'b0;
         tmo_q     <= (active && !unit_new && !tmo_hit) ? tmo_q + 1'b1 : '0;
         if (unit_new) begin
            last_q <= s_strb;
            ack_q  <= ~ack_q;
         end
         unique case (st_q)
            ST_IDLE: if (wake) begin
               st_q   <= ST_HDR;
               mode_q <= cfg_byte_mode;
               ack_q  <= 1'b1;
               last_q <= 1'b1;
               hcnt_q <= '0;
            end
            ST_HDR: if (byte_v) begin
               hdr_q[hcnt_q] <= byte_d;
               hcnt_q        <= hcnt_q + 1'b1;
               if (hcnt_q == 2'(HDR_BYTES - 1)) begin
                  if (hdr_ok) begin
                     rem_q <= hdr_len;
                     st_q  <= (hdr_len == '0) ? ST_FIN : ST_PAY;
                  end else begin
                     st_q   <= ST_IDLE;
                     ack_q  <= 1'b0;
                     rx_err <= 1'b1;
                  end
               end
            end
            ST_PAY: if (byte_v) begin
               pay_valid <= 1'b1;
               pay_data  <= byte_d;
               pay_last  <= (rem_q == LEN_W'(1));
               rem_q     <= rem_q - 1'b1;
               if (rem_q == LEN_W'(1)) st_q <= ST_FIN;
            end
            ST_FIN: if (!s_strb) begin
               st_q  <= ST_IDLE;
               ack_q <= 1'b0;
            end
            default: st_q <= ST_IDLE;
         endcase
         if (tmo_hit) begin
            st_q   <= ST_IDLE;
            ack_q  <= 1'b0;
            rx_err <= 1'b1;
         end
      end
   end

   assign data_out = {4'b0000, ack_q, 2'b00, active & mode_q};
   assign ctrl_out = active ? CTRL_ACTIVE : 4'b0000;

   AST_ACK_ON_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active) && !$stable(ack_q)) |-> $past(unit_new)); // R6
   AST_IDLE_NO_PAY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |-> !pay_valid); // R7
   AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      pay_last |-> pay_valid); // R8
   AST_ERR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      rx_err |-> (st_q == ST_IDLE && !ack_q)); // R11
   AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_q <= TMO_W'(TMO_CYC - 1)); // R11
   AST_FIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FIN && s_strb) |=> $stable(ack_q)); // R10
endmodule

// File: tb/lnk_rx_tb_top.sv
`timescale 1ns/1ps
module lnk_rx_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_byte_mode = 1'b0;
   logic [4:0] stat_pin = '0;
   logic [3:0] ctrl_pin = '0;
   logic [7:0] data_out;
   logic [3:0] ctrl_out;
   logic       pay_valid, pay_last, rx_err;
   logic [7:0] pay_data;

   always #10 clk = ~clk;

   lnk_rx #(.SYNC_STG(2), .TMO_CYC(40)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_byte_mode(cfg_byte_mode),
      .stat_in(stat_pin), .ctrl_in(ctrl_pin),
      .data_out(data_out), .ctrl_out(ctrl_out),
      .pay_valid(pay_valid), .pay_data(pay_data), .pay_last(pay_last),
      .rx_err(rx_err));

   int   n_chk = 0;
   int   n_fail = 0;
   int   err_seen = 0;
   int   pay_seen = 0;
   logic [7:0] exp_b[$];
   logic       exp_l[$];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // reference stream model, compared every clock
   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_err) err_seen++;
         if (pay_valid) begin
            pay_seen++;
            if (exp_b.size() == 0) begin
               n_chk++; n_fail++;
               $display("FAIL R8 unexpected byte actual=%0h expected=none", pay_data);
            end else begin
               chk("R8 payload byte (R4/R5 mapping)", pay_data, exp_b.pop_front());
               chk("R8 last marker", pay_last, exp_l.pop_front());
            end
         end
      end
   end

   task automatic send_unit(input logic [3:0] nib, input logic [3:0] hi, input bit do_chk);
      @(negedge clk);
      stat_pin[0] = nib[0];
      stat_pin[1] = nib[1];
      stat_pin[2] = nib[2];
      stat_pin[4] = ~nib[3];
      ctrl_pin    = hi;
      repeat (2) @(negedge clk);
      stat_pin[3] = ~stat_pin[3];
      repeat (7) @(negedge clk);
      if (do_chk) chk("R6 ack follows strobe", data_out[3], stat_pin[3]);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit bm, input bit do_chk);
      if (bm) send_unit(b[3:0], b[7:4], do_chk);
      else begin
         send_unit(b[3:0], 4'h0, 1'b1);
         send_unit(b[7:4], 4'h0, do_chk);
      end
   endtask

   task automatic wake(input bit bm);
      @(negedge clk);
      cfg_byte_mode = bm;
      stat_pin[3]   = 1'b1;
      repeat (6) @(negedge clk);
      chk("R2 strobe drive high", data_out[3], 1'b1);
      chk("R2 width advertised", data_out[0], bm);
      chk("R2 control drive", ctrl_out, 4'b0100);
      chk("R2 other data bits", {data_out[7:4], data_out[2:1]}, '0);
   endtask

   task automatic expect_pay(input logic [7:0] b, input bit l);
      exp_b.push_back(b);
      exp_l.push_back(l);
   endtask

   task automatic close_link();
      repeat (10) @(negedge clk);
      chk("R10 strobe held until sender drops", data_out[3], 1'b1);
      stat_pin[3] = 1'b0;
      repeat (6) @(negedge clk);
      chk("R10 data drive released", data_out, 8'h00);
      chk("R10 control drive released", ctrl_out, 4'h0);
   endtask

   task automatic send_hdr(input logic [15:0] len, input bit bm);
      send_byte(len[7:0], bm, 1'b1);
      send_byte(len[15:8], bm, 1'b1);
      send_byte(~len[7:0], bm, 1'b1);
      send_byte(~len[15:8], bm, 1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      int e0, p0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 data_out", data_out, 8'h00);
      chk("R1 ctrl_out", ctrl_out, 4'h0);
      chk("R1 pay_valid", pay_valid, 1'b0);
      chk("R1 pay_last", pay_last, 1'b0);
      chk("R1 rx_err", rx_err, 1'b0);

      // R3 idle ignores non-strobe pins
      stat_pin = 5'b10111; ctrl_pin = 4'hF; cfg_byte_mode = 1'b1;
      repeat (8) @(negedge clk);
      chk("R3 idle data_out", data_out, 8'h00);
      chk("R3 idle ctrl_out", ctrl_out, 4'h0);
      stat_pin = '0; ctrl_pin = '0;
      repeat (4) @(negedge clk);

      // byte mode, length 2 (R2 R4 R6 R8 R10), mode flipped mid-way (R3)
      wake(1'b1);
      cfg_byte_mode = 1'b0;
      send_hdr(16'd2, 1'b1);
      expect_pay(8'hA5, 1'b0);
      expect_pay(8'h3C, 1'b1);
      send_byte(8'hA5, 1'b1, 1'b1);
      send_byte(8'h3C, 1'b1, 1'b1);
      chk("R3 width stays latched", data_out[0], 1'b1);
      close_link();

      // nibble mode, length 3 (R5)
      wake(1'b0);
      send_hdr(16'd3, 1'b0);
      expect_pay(8'h5A, 1'b0);
      expect_pay(8'hC3, 1'b0);
      expect_pay(8'h81, 1'b1);
      send_byte(8'h5A, 1'b0, 1'b1);
      send_byte(8'hC3, 1'b0, 1'b1);
      send_byte(8'h81, 1'b0, 1'b1);
      repeat (3) @(negedge clk);
      chk("R5 nibble payload count", exp_b.size(), 0);
      close_link();

      // zero length (R9)
      p0 = pay_seen;
      wake(1'b1);
      send_hdr(16'd0, 1'b1);
      repeat (3) @(negedge clk);
      chk("R9 no payload for zero length", pay_seen, p0);
      close_link();

      // header mismatch (R7)
      e0 = err_seen; p0 = pay_seen;
      wake(1'b1);
      send_byte(8'h01, 1'b1, 1'b1);
      send_byte(8'h00, 1'b1, 1'b1);
      send_byte(8'hFE, 1'b1, 1'b1);
      send_byte(8'hFE, 1'b1, 1'b0);
      chk("R7 error pulse", err_seen, e0 + 1);
      chk("R7 data drive released", data_out, 8'h00);
      chk("R7 control drive released", ctrl_out, 4'h0);
      send_byte(8'h77, 1'b1, 1'b0);
      repeat (4) @(negedge clk);
      chk("R7 no payload after bad header", pay_seen, p0);
      chk("R7 still idle after stray unit", data_out, 8'h00);
      stat_pin[3] = 1'b0;
      repeat (6) @(negedge clk);

      // stall timeout (R11), nibble mode left half-full
      e0 = err_seen;
      wake(1'b0);
      send_unit(4'h3, 4'h0, 1'b1);
      repeat (60) @(negedge clk);
      chk("R11 timeout error pulse", err_seen, e0 + 1);
      chk("R11 data drive released", data_out, 8'h00);
      chk("R11 control drive released", ctrl_out, 4'h0);

      // recovery in byte mode, length 1, strobe ends low (R4 R10)
      wake(1'b1);
      send_hdr(16'd1, 1'b1);
      expect_pay(8'hE6, 1'b1);
      send_byte(8'hE6, 1'b1, 1'b1);
      repeat (4) @(negedge clk);
      chk("R10 idle once sender strobe low", data_out, 8'h00);
      chk("R8 all expected bytes seen", exp_b.size(), 0);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule